// File: doc/BRIEF.md
# Bit-Addressable Peripheral Register Space

This block holds the 64 byte-wide I/O locations that sit beside a small 8-bit processor core. The core reaches them in three ways. Port commands address the locations directly. Data-space commands reach the same bytes at an offset of 0x20. Single-bit commands set, clear or test one bit. A read returns its byte in the same cycle. A write or a bit change takes effect at the next rising clock edge. A bit set or clear rewrites the whole byte. On a register whose flags are cleared by writing 1, every flag that currently reads 1 is therefore written back as 1 and is cleared.

The location at I/O address 0x3F is the processor status byte. It holds the global interrupt enable, the bit-copy T bit and six arithmetic flags. The global interrupt enable is a two-state machine with the states `GIE_OFF` and `GIE_ON`:
- ENABLE moves it from `GIE_OFF` to `GIE_ON`. It fires on a return-from-interrupt strobe, or on a bus write with bit 7 set, in a cycle that has no interrupt-taken strobe.
- DISABLE moves it from `GIE_ON` to `GIE_OFF`. It fires on an interrupt-taken strobe, or on a bus write with bit 7 clear that has no return strobe.
- HOLD keeps the current state in every other cycle.

The other locations are placeholders for peripherals:
- general registers at I/O 0x00–0x07 and 0x20–0x27;
- a flag register, cleared by writing 1, at 0x08;
- a control register at 0x09 that implements only bits 5:0.

All other addresses are reserved.

Top module: `iosp_space`

## Requirements
- R1: Port commands use cmd=1 (read) and cmd=2 (write) with addresses 0x00–0x3F. A read drives `rdata` combinationally in the same cycle. A write becomes visible after the next rising edge. A port address of 0x40 or above raises `reject`, has no effect and gives `rdata`=0.
- R2: Data-space commands use cmd=3 (read) and cmd=4 (write). Addresses 0x20–0x5F reach I/O location (address − 0x20). Any other address raises `reject` and has no effect. cmd=0 is a no-operation and never rejects.
- R3: Bit commands use cmd=5 (set), cmd=6 (clear) and cmd=7 (test), with `bit_sel` selecting the bit. They are accepted only at I/O 0x00–0x1F. At a higher address they raise `reject`, change nothing and drive `test_bit`=0 and `skip`=0.
- R4: A bit set or clear writes back the whole current byte with only the selected bit changed. At the flag register, that write-back clears every flag that read 1, except a flag whose bit the clear command forced to 0.
- R5: The flag register at I/O 0x08 sets bit k when `flag_hw_set[k]` is high. Writing 1 to a bit clears it and writing 0 leaves it unchanged. A hardware set wins over a clear in the same cycle.
- R6: A bit test drives `test_bit` with the selected bit and raises `skip` when that bit equals `test_pol`.
- R7: The status byte at I/O 0x3F (data 0x5F) has bit 7 as the interrupt enable, bit 6 as T, and bits 5..0 as the H, S, V, N, Z and C flags. It is readable and writable as a whole byte.
- R8: `irq_taken` clears the interrupt enable and `irq_return` sets it. When both arrive together, `irq_taken` wins. Either strobe wins over a bus write to bit 7 in the same cycle.
- R9: `t_store` copies `t_src` into T and wins over a bus write to bit 6. `t_bit` always shows T.
- R10: Reserved addresses (0x0A–0x1F and 0x28–0x3E) read as 0 and ignore writes. Bits 7:6 of the control register at 0x09 read as 0.
- R11: Reset clears every register, including the status byte, to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 3 | Access type code |
| addr | input | 7 | I/O or data-space address |
| bit_sel | input | 3 | Bit index for bit commands |
| wdata | input | 8 | Write data |
| test_pol | input | 1 | Bit value that makes a bit test skip |
| flag_hw_set | input | 8 | Per-bit hardware set of the flag register |
| irq_taken | input | 1 | Interrupt accepted strobe |
| irq_return | input | 1 | Return-from-interrupt strobe |
| t_store | input | 1 | Bit-store strobe into T |
| t_src | input | 1 | Register-file bit to store into T |
| rdata | output | 8 | Read data, 0 when not reading |
| test_bit | output | 1 | Value of the tested bit |
| skip | output | 1 | Bit test matched `test_pol` |
| reject | output | 1 | Command addressed outside its window |
| t_bit | output | 1 | Current T value for a bit-load |

## Verification
If the address decode goes wrong, it shows in the same cycle as a wrong `rdata` or a wrong `reject`. A corrupt stored byte shows on the first read or bit test of that location after the faulty edge. An error in the enable state machine or in T appears one cycle after the strobe, on `t_bit` and on a read of 0x3F. A mistaken flag write-back appears on the read of 0x08 that follows the bit command.

// File: rtl/iosp_pkg.sv
`timescale 1ns/1ps
package iosp_pkg;
    localparam int IO_AW  = 6;
    localparam int BUS_AW = 7;
    localparam int DW     = 8;
    localparam logic [BUS_AW-1:0] DATA_OFS  = 7'h20;
    localparam logic [BUS_AW-1:0] IO_SPAN   = 7'h40;
    localparam logic [BUS_AW-1:0] BIT_LIMIT = 7'h20;
    localparam logic [IO_AW-1:0]  SREG_IDX  = 6'h3F;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_PRD  = 3'd1,
        CMD_PWR  = 3'd2,
        CMD_DRD  = 3'd3,
        CMD_DWR  = 3'd4,
        CMD_BSET = 3'd5,
        CMD_BCLR = 3'd6,
        CMD_BTST = 3'd7
    } iosp_cmd_e;

    typedef enum logic {
        GIE_OFF = 1'b0,
        GIE_ON  = 1'b1
    } gie_state_e;

    typedef struct packed {
        logic             valid;
        logic             reject;
        logic [IO_AW-1:0] idx;
        logic             rd;
        logic             wr;
        logic             set;
        logic             clr;
        logic             tst;
    } iosp_dec_t;
endpackage

// File: rtl/iosp_decode.sv
`timescale 1ns/1ps
module iosp_decode
    import iosp_pkg::*;
(
    input  logic [2:0]        cmd_i,
    input  logic [BUS_AW-1:0] addr_i,
    output iosp_dec_t         dec_o
);
    logic              port_ok;
    logic              data_ok;
    logic              bit_ok;
    logic [BUS_AW-1:0] data_rel;

    assign port_ok  = addr_i < IO_SPAN;
    assign data_ok  = (addr_i >= DATA_OFS) && (addr_i < (DATA_OFS + IO_SPAN));
    assign bit_ok   = addr_i < BIT_LIMIT;
    assign data_rel = addr_i - DATA_OFS;

    always_comb begin
        dec_o = '0;
        unique case (iosp_cmd_e'(cmd_i))
            CMD_NOP: ;
            CMD_PRD, CMD_PWR: begin
                dec_o.valid  = port_ok;
                dec_o.reject = !port_ok;
                dec_o.idx    = addr_i[IO_AW-1:0];
                dec_o.rd     = port_ok && (cmd_i == CMD_PRD);
                dec_o.wr     = port_ok && (cmd_i == CMD_PWR);
            end
            CMD_DRD, CMD_DWR: begin
                dec_o.valid  = data_ok;
                dec_o.reject = !data_ok;
                dec_o.idx    = data_rel[IO_AW-1:0];
                dec_o.rd     = data_ok && (cmd_i == CMD_DRD);
                dec_o.wr     = data_ok && (cmd_i == CMD_DWR);
            end
            CMD_BSET, CMD_BCLR, CMD_BTST: begin
                dec_o.valid  = bit_ok;
                dec_o.reject = !bit_ok;
                dec_o.idx    = addr_i[IO_AW-1:0];
                dec_o.set    = bit_ok && (cmd_i == CMD_BSET);
                dec_o.clr    = bit_ok && (cmd_i == CMD_BCLR);
                dec_o.tst    = bit_ok && (cmd_i == CMD_BTST);
            end
        endcase
    end
endmodule

// File: rtl/iosp_regfile.sv
`timescale 1ns/1ps
module iosp_regfile
    import iosp_pkg::*;
#(
    parameter logic [IO_AW-1:0] GP_LO_BASE = 6'h00,
    parameter int               GP_LO_N    = 8,
    parameter logic [IO_AW-1:0] GP_HI_BASE = 6'h20,
    parameter int               GP_HI_N    = 8,
    parameter logic [IO_AW-1:0] FLAG_IDX   = 6'h08,
    parameter logic [IO_AW-1:0] CTRL_IDX   = 6'h09,
    parameter logic [DW-1:0]    CTRL_MASK  = 8'h3F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IO_AW-1:0] idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [DW-1:0]    flag_hw_set,
    output logic [DW-1:0]    rd_byte,
    output logic [DW-1:0]    flag_q
);
    localparam int LO_IW = (GP_LO_N > 1) ? $clog2(GP_LO_N) : 1;
    localparam int HI_IW = (GP_HI_N > 1) ? $clog2(GP_HI_N) : 1;

    logic [IO_AW-1:0] lo_off;
    logic [IO_AW-1:0] hi_off;
    logic             lo_hit;
    logic             hi_hit;
    logic [DW-1:0]    gp_lo_q [GP_LO_N];
    logic [DW-1:0]    gp_hi_q [GP_HI_N];
    logic [DW-1:0]    ctrl_q;

    assign lo_off = idx - GP_LO_BASE;
    assign hi_off = idx - GP_HI_BASE;
    assign lo_hit = lo_off < IO_AW'(GP_LO_N);
    assign hi_hit = hi_off < IO_AW'(GP_HI_N);

    for (genvar g = 0; g < GP_LO_N; g++) begin : g_lo
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                gp_lo_q[g] <= '0;
            else if (wr_en && lo_hit && (lo_off[LO_IW-1:0] == LO_IW'(g)))
                gp_lo_q[g] <= wr_data;
        end
    end

    for (genvar g = 0; g < GP_HI_N; g++) begin : g_hi
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                gp_hi_q[g] <= '0;
            else if (wr_en && hi_hit && (hi_off[HI_IW-1:0] == HI_IW'(g)))
                gp_hi_q[g] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
            ctrl_q <= '0;
        end else begin
            flag_q <= (flag_q & ~((wr_en && idx == FLAG_IDX) ? wr_data : '0)) | flag_hw_set;
            if (wr_en && idx == CTRL_IDX)
                ctrl_q <= wr_data & CTRL_MASK;
        end
    end

    always_comb begin
        rd_byte = '0;
        if (lo_hit)
            rd_byte = gp_lo_q[lo_off[LO_IW-1:0]];
        else if (hi_hit)
            rd_byte = gp_hi_q[hi_off[HI_IW-1:0]];
        else if (idx == FLAG_IDX)
            rd_byte = flag_q;
        else if (idx == CTRL_IDX)
            rd_byte = ctrl_q;
    end
endmodule

// File: rtl/iosp_status.sv
`timescale 1ns/1ps
module iosp_status
    import iosp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          irq_taken,
    input  logic          irq_return,
    input  logic          t_store,
    input  logic          t_src,
    output logic [DW-1:0] sreg,
    output logic          gie_on
);
    gie_state_e state_q;
    gie_state_e state_d;
    logic       t_q;
    logic [5:0] alu_flags_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= GIE_OFF;
            t_q         <= 1'b0;
            alu_flags_q <= '0;
        end else begin
            state_q <= state_d;
            if (t_store)
                t_q <= t_src;
            else if (wr_en)
                t_q <= wr_data[6];
            if (wr_en)
                alu_flags_q <= wr_data[5:0];
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GIE_OFF: begin
                if (!irq_taken && (irq_return || (wr_en && wr_data[7])))
                    state_d = GIE_ON;
            end
            GIE_ON: begin
                if (irq_taken || (!irq_return && wr_en && !wr_data[7]))
                    state_d = GIE_OFF;
            end
        endcase
    end

    always_comb begin
        gie_on = (state_q == GIE_ON);
        sreg   = {gie_on, t_q, alu_flags_q};
    end
endmodule

// File: rtl/iosp_space.sv
`timescale 1ns/1ps
module iosp_space
    import iosp_pkg::*;
#(
    parameter int            GP_LO_N   = 8,
    parameter int            GP_HI_N   = 8,
    parameter logic [DW-1:0] CTRL_MASK = 8'h3F
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  cmd,
    input  logic [6:0]  addr,
    input  logic [2:0]  bit_sel,
    input  logic [7:0]  wdata,
    input  logic        test_pol,
    input  logic [7:0]  flag_hw_set,
    input  logic        irq_taken,
    input  logic        irq_return,
    input  logic        t_store,
    input  logic        t_src,
    output logic [7:0]  rdata,
    output logic        test_bit,
    output logic        skip,
    output logic        reject,
    output logic        t_bit
);
    iosp_dec_t     dec;
    logic [DW-1:0] rf_byte;
    logic [DW-1:0] sreg;
    logic [DW-1:0] cur;
    logic [DW-1:0] bit_mask;
    logic [DW-1:0] wr_data;
    logic          wr_en;
    logic          sreg_sel;
    logic          gie_on;
    logic [DW-1:0] flag_q;

    iosp_decode i_dec (
        .cmd_i  (cmd),
        .addr_i (addr),
        .dec_o  (dec)
    );

    iosp_regfile #(
        .GP_LO_N   (GP_LO_N),
        .GP_HI_N   (GP_HI_N),
        .CTRL_MASK (CTRL_MASK)
    ) i_rf (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .idx         (dec.idx),
        .wr_data     (wr_data),
        .flag_hw_set (flag_hw_set),
        .rd_byte     (rf_byte),
        .flag_q      (flag_q)
    );

    iosp_status i_st (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en && sreg_sel),
        .wr_data    (wr_data),
        .irq_taken  (irq_taken),
        .irq_return (irq_return),
        .t_store    (t_store),
        .t_src      (t_src),
        .sreg       (sreg),
        .gie_on     (gie_on)
    );

    assign sreg_sel = (dec.idx == SREG_IDX);
    assign cur      = sreg_sel ? sreg : rf_byte;
    assign bit_mask = DW'(1) << bit_sel;

    always_comb begin
        wr_en   = dec.valid && (dec.wr || dec.set || dec.clr);
        wr_data = wdata;
        if (dec.set)
            wr_data = cur | bit_mask;
        else if (dec.clr)
            wr_data = cur & ~bit_mask;
    end

    always_comb begin
        rdata    = dec.rd ? cur : '0;
        test_bit = dec.tst && cur[bit_sel];
        skip     = dec.tst && (cur[bit_sel] == test_pol);
        reject   = dec.reject;
        t_bit    = sreg[6];
    end
endmodule

// File: rtl/iosp_space_chk.sv
`timescale 1ns/1ps
module iosp_space_chk
    import iosp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cmd,
    input logic [6:0] addr,
    input logic       test_pol,
    input logic [7:0] flag_hw_set,
    input logic       irq_taken,
    input logic       irq_return,
    input logic       t_store,
    input logic       t_src,
    input logic [7:0] rdata,
    input logic       test_bit,
    input logic       skip,
    input logic       reject,
    input logic       t_bit,
    input logic       gie_on,
    input logic [7:0] flag_q
);
    logic is_port, is_data, is_bitop;
    assign is_port  = (cmd == CMD_PRD) || (cmd == CMD_PWR);
    assign is_data  = (cmd == CMD_DRD) || (cmd == CMD_DWR);
    assign is_bitop = (cmd == CMD_BSET) || (cmd == CMD_BCLR) || (cmd == CMD_BTST);

    AST_PORT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (is_port && addr >= 7'h40) |-> (reject && rdata == 8'h00)); // R1
    AST_DATA_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (is_data && (addr < 7'h20 || addr >= 7'h60)) |-> reject); // R2
    AST_BIT_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (is_bitop && addr >= 7'h20) |-> (reject && !skip && !test_bit)); // R3
    AST_SKIP_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> (cmd == CMD_BTST && test_bit == test_pol)); // R6
    AST_FLAG_HW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_hw_set != 8'h00) |=> ((flag_q & $past(flag_hw_set)) == $past(flag_hw_set))); // R5
    AST_GIE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |=> !gie_on); // R8
    AST_GIE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_return && !irq_taken) |=> gie_on); // R8
    AST_T_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        t_store |=> (t_bit == $past(t_src))); // R9
endmodule

bind iosp_space iosp_space_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd         (cmd),
    .addr        (addr),
    .test_pol    (test_pol),
    .flag_hw_set (flag_hw_set),
    .irq_taken   (irq_taken),
    .irq_return  (irq_return),
    .t_store     (t_store),
    .t_src       (t_src),
    .rdata       (rdata),
    .test_bit    (test_bit),
    .skip        (skip),
    .reject      (reject),
    .t_bit       (t_bit),
    .gie_on      (gie_on),
    .flag_q      (flag_q)
);

// File: tb/test_iosp_space.sv
`timescale 1ns/1ps
module test_iosp_space;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd = '0;
    logic [6:0] addr = '0;
    logic [2:0] bit_sel = '0;
    logic [7:0] wdata = '0;
    logic       test_pol = 1'b0;
    logic [7:0] flag_hw_set = '0;
    logic       irq_taken = 1'b0, irq_return = 1'b0, t_store = 1'b0, t_src = 1'b0;
    logic [7:0] rdata;
    logic       test_bit, skip, reject, t_bit;
    int         total = 0;
    int         bad = 0;

    always #2.5 clk = ~clk;

    iosp_space i_iosp_space (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .bit_sel(bit_sel),
        .wdata(wdata), .test_pol(test_pol), .flag_hw_set(flag_hw_set),
        .irq_taken(irq_taken), .irq_return(irq_return), .t_store(t_store),
        .t_src(t_src), .rdata(rdata), .test_bit(test_bit), .skip(skip),
        .reject(reject), .t_bit(t_bit)
    );

    // fields: req cmd addr bit wdata pol | exp rdata test_bit skip reject
    localparam int NV = 26;
    localparam logic [36:0] VEC [NV] = '{
        {4'd1, 3'd2, 7'h03, 3'd0, 8'hA5, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R1 write
        {4'd1, 3'd1, 7'h03, 3'd0, 8'h00, 1'b0, 8'hA5, 1'b0, 1'b0, 1'b0}, // R1 read
        {4'd2, 3'd3, 7'h23, 3'd0, 8'h00, 1'b0, 8'hA5, 1'b0, 1'b0, 1'b0}, // R2 alias
        {4'd2, 3'd4, 7'h41, 3'd0, 8'h3C, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R2 write
        {4'd2, 3'd1, 7'h21, 3'd0, 8'h00, 1'b0, 8'h3C, 1'b0, 1'b0, 1'b0}, // R2
        {4'd4, 3'd5, 7'h03, 3'd1, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R4 set
        {4'd4, 3'd1, 7'h03, 3'd0, 8'h00, 1'b0, 8'hA7, 1'b0, 1'b0, 1'b0}, // R4
        {4'd4, 3'd6, 7'h03, 3'd7, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R4 clear
        {4'd4, 3'd1, 7'h03, 3'd0, 8'h00, 1'b0, 8'h27, 1'b0, 1'b0, 1'b0}, // R4
        {4'd6, 3'd7, 7'h03, 3'd0, 8'h00, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0}, // R6
        {4'd6, 3'd7, 7'h03, 3'd3, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0}, // R6
        {4'd6, 3'd7, 7'h03, 3'd3, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0}, // R6
        {4'd3, 3'd5, 7'h21, 3'd0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, // R3
        {4'd3, 3'd1, 7'h21, 3'd0, 8'h00, 1'b0, 8'h3C, 1'b0, 1'b0, 1'b0}, // R3 unchanged
        {4'd3, 3'd7, 7'h21, 3'd2, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1}, // R3
        {4'd1, 3'd2, 7'h45, 3'd0, 8'h11, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, // R1
        {4'd2, 3'd3, 7'h1F, 3'd0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, // R2
        {4'd2, 3'd3, 7'h60, 3'd0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, // R2
        {4'd10, 3'd2, 7'h0C, 3'd0, 8'hFF, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R10
        {4'd10, 3'd1, 7'h0C, 3'd0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R10
        {4'd10, 3'd2, 7'h09, 3'd0, 8'hFF, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R10
        {4'd10, 3'd1, 7'h09, 3'd0, 8'h00, 1'b0, 8'h3F, 1'b0, 1'b0, 1'b0}, // R10
        {4'd7, 3'd4, 7'h5F, 3'd0, 8'hC5, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R7
        {4'd7, 3'd1, 7'h3F, 3'd0, 8'h00, 1'b0, 8'hC5, 1'b0, 1'b0, 1'b0}, // R7
        {4'd3, 3'd5, 7'h3F, 3'd0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, // R3
        {4'd7, 3'd3, 7'h5F, 3'd0, 8'h00, 1'b0, 8'hC5, 1'b0, 1'b0, 1'b0}  // R7
    };

    task automatic chk(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive after a rising edge, then wait to the falling edge to sample
    task automatic drv(input logic [2:0] c, input logic [6:0] a, input logic [2:0] b,
                       input logic [7:0] w, input logic p, input logic tk, input logic rt,
                       input logic ts, input logic tv, input logic [7:0] hs);
        @(posedge clk); #1;
        cmd = c; addr = a; bit_sel = b; wdata = w; test_pol = p;
        irq_taken = tk; irq_return = rt; t_store = ts; t_src = tv; flag_hw_set = hs;
        @(negedge clk);
    endtask

    task automatic rd(input logic [6:0] a);
        drv(3'd1, a, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic nop_hs(input logic [7:0] hs);
        drv(3'd0, 7'h00, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, hs);
    endtask

    initial begin
        #(5.0 * 100000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R11 reset state
        rd(7'h00); chk(11, "reset gp", rdata, 8'h00);
        rd(7'h08); chk(11, "reset flags", rdata, 8'h00);
        rd(7'h3F); chk(11, "reset sreg", rdata, 8'h00);
        nop_hs(8'h00); chk(2, "nop no reject", {7'b0, reject}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [36:0] v;
            v = VEC[i];
            drv(v[32:30], v[29:23], v[22:20], v[19:12], v[11], 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
            chk(int'(v[36:33]), $sformatf("vec%0d out", i),
                rdata, v[10:3]);
            chk(int'(v[36:33]), $sformatf("vec%0d flags", i),
                {5'b0, test_bit, skip, reject}, {5'b0, v[2:0]});
        end
        chk(9, "t after sreg write", {7'b0, t_bit}, 8'h01);

        // R5 flag register
        nop_hs(8'h05); rd(7'h08); chk(5, "hw set", rdata, 8'h05);
        drv(3'd2, 7'h08, 3'd0, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        rd(7'h08); chk(5, "w1c", rdata, 8'h04);
        nop_hs(8'h0A); rd(7'h08); chk(5, "hw set 2", rdata, 8'h0E);
        // R4 bit set on flags clears all set flags
        drv(3'd5, 7'h08, 3'd4, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        rd(7'h08); chk(4, "bset side effect", rdata, 8'h00);
        nop_hs(8'h03);
        drv(3'd6, 7'h08, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        rd(7'h08); chk(4, "bclr side effect", rdata, 8'h01);
        drv(3'd2, 7'h08, 3'd0, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01);
        rd(7'h08); chk(5, "set wins", rdata, 8'h01);
        drv(3'd2, 7'h08, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        rd(7'h08); chk(5, "write 0 keeps", rdata, 8'h01);

        // R8 interrupt enable
        drv(3'd0, 7'h00, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        rd(7'h3F); chk(8, "taken clears", rdata, 8'h45);
        drv(3'd0, 7'h00, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
        rd(7'h3F); chk(8, "return sets", rdata, 8'hC5);
        drv(3'd0, 7'h00, 3'd0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
        rd(7'h3F); chk(8, "taken wins", rdata, 8'h45);
        drv(3'd2, 7'h3F, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
        rd(7'h3F); chk(8, "return over write", rdata, 8'h80);
        drv(3'd2, 7'h3F, 3'd0, 8'h80, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        rd(7'h3F); chk(8, "taken over write", rdata, 8'h00);

        // R9 bit-copy storage
        drv(3'd2, 7'h3F, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
        rd(7'h3F); chk(9, "t store read", rdata, 8'h40);
        chk(9, "t_bit set", {7'b0, t_bit}, 8'h01);
        drv(3'd0, 7'h00, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
        nop_hs(8'h00); chk(9, "t_bit clear", {7'b0, t_bit}, 8'h00);

        // R11 reset mid-run
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        rd(7'h03); chk(11, "reset gp lo", rdata, 8'h00);
        rd(7'h21); chk(11, "reset gp hi", rdata, 8'h00);
        rd(7'h09); chk(11, "reset ctrl", rdata, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule